// File: doc/BRIEF.md
# Wide Interval Timer with Split-Half Access

The block is a timer peripheral whose count and period are twice as wide as its register bus, 64 bits behind a 32-bit data path by default. Software programs a period, picks a mode and starts the timer; the counter advances once per count tick and, on reaching the period, returns to zero and raises a status flag that can drive an interrupt line. Counting is either continuous or single-shot. A 4-bit divide value P slows the count to one tick every P+1 enabled clock cycles. The enabled cycles are either every cycle of the bus clock or only the cycles in which an alternate-clock enable input is high.

Because both wide quantities cross a narrow bus, each is moved in two halves with a fixed order. A read of the low counter half captures the upper half at the same instant, so a following read of the upper half returns a coherent value. A write to the upper period half is only held in a staging register until the write to the lower half commits all 64 bits at once. A mode bit lets a committed period apply to a running timer at once. Without that bit, the new period waits for the next start. Read data appears on the bus one cycle after the read strobe.

Top module: `ivt64_timer`

## Requirements
- R1: After reset every readable offset returns zero, the counter is stopped at zero and the interrupt output is low.
- R2: Writing 1 to bit 0 at offset 0x00 while the timer is stopped clears the counter and starts it. The same write while it runs is ignored and the count carries on undisturbed.
- R3: With divide value P in bits 11:8 of the mode register (offset 0x04), the counter advances once every P+1 enabled clock cycles. The mode register reads back as written.
- R4: With mode bit 3 set, only cycles in which `alt_tick` is high are enabled cycles. With `alt_tick` held low the count does not move.
- R5: With committed period N, the counter counts 0 to N-1. On the tick that would make it N it returns to zero and sets bit 0 of the status register at offset 0x1C.
- R6: With mode bit 0 set the timer keeps wrapping. With it clear, the counter stops at zero after the first wrap until the next start.
- R7: `irq_o` is high exactly while status bit 0 and enable bit 0 (offset 0x10) are both set. Reading the status register returns the flag and clears it, unless a wrap occurs in that same cycle.
- R8: A read of the low counter half (offset 0x20) captures the upper half. A later read of offset 0x24 returns that captured value, even after the live upper half has changed.
- R9: A write to offset 0x0C only stages the upper period half. A write to offset 0x08 commits {staged upper, written lower} as the period. Offsets 0x08 and 0x0C read back the committed period.
- R10: With mode bit 4 set, a committed period takes effect on the running timer at once. If the counter already lies at or beyond the new period, it wraps on the next tick. With bit 4 clear, a period committed while running is held and applied at the next accepted start.
- R11: A committed period of zero acts as the largest value, so the counter runs through the whole range without an early wrap.
- R12: Writing 1 to bit 8 at offset 0x00 stops the counter, clears it and returns every register to its reset value. It takes priority over a start in the same write.
- R13: Offset 0x00 and every offset not listed above, including unaligned ones, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alt_tick | input | 1 | Alternate-clock enable, used when mode bit 3 is set |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | HALF_W | Write data |
| bus_rdata | output | HALF_W | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request, status flag AND enable |

## Verification
A counter that misses a tick shows up at the next low-half read as a value one short of the value the bench works out from the start cycle. A wrong compare moves the status flag and `irq_o` by at least one count tick, which becomes visible within one period. A lost or stale capture of the upper half only shows once the count crosses a half boundary, so the bench reads the low half just below that boundary and the high half just after it. A period applied at the wrong time shows in the first counter read after the commit, or in the stop cycle of a single-shot run.

// File: rtl/ivt64_pkg.sv
package ivt64_pkg;

    // register byte offsets (fixed: software depends on them)
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h04;
    localparam logic [7:0] OFS_PLO  = 8'h08;
    localparam logic [7:0] OFS_PHI  = 8'h0C;
    localparam logic [7:0] OFS_IEN  = 8'h10;
    localparam logic [7:0] OFS_IST  = 8'h1C;
    localparam logic [7:0] OFS_CLO  = 8'h20;
    localparam logic [7:0] OFS_CHI  = 8'h24;

    // control bits
    localparam int CTL_GO   = 0;
    localparam int CTL_SRST = 8;

    // mode bits
    localparam int MD_CONT = 0;
    localparam int MD_ALT  = 3;
    localparam int MD_LIVE = 4;
    localparam int MD_DIV  = 8;
    localparam int DIV_W   = 4;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             live;
        logic             alt;
        logic             cont;
    } mode_t;

endpackage

// File: rtl/ivt64_prescale.sv
module ivt64_prescale
    import ivt64_pkg::*;
#(
    parameter int PW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          alt_sel,
    input  logic          alt_tick,
    input  logic [PW-1:0] div,
    output logic          tick
);

    typedef struct packed {
        logic [PW-1:0] phase;
    } ps_st_t;

    ps_st_t st_q, st_d;
    logic   src_en;
    logic   at_end;

    always_comb begin
        src_en = alt_sel ? alt_tick : 1'b1;
        // >= keeps the divider from running away if div shrinks mid-count
        at_end = (st_q.phase >= div);
        tick   = run & src_en & at_end;

        st_d = st_q;
        if (clr) begin
            st_d.phase = '0;
        end else if (run && src_en) begin
            if (at_end) begin
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ivt64_count.sv
module ivt64_count #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             swrst,
    input  logic             tick,
    input  logic             cont,
    input  logic             live,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_val,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             launch,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] eff;
        logic [CNT_W-1:0] pend;
        logic             pend_vld;
        logic             run;
    } cnt_st_t;

    cnt_st_t          st_q, st_d;
    logic [CNT_W:0]   lim_w;
    logic [CNT_W:0]   inc_w;
    logic             hit_w;

    always_comb begin
        // zero period stands for the full range
        lim_w  = (st_q.eff == '0) ? {1'b0, {CNT_W{1'b1}}} : {1'b0, st_q.eff};
        inc_w  = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        hit_w  = (inc_w >= lim_w);
        launch = start_req & ~st_q.run & ~swrst;
        wrap   = tick & st_q.run & hit_w;
    end

    always_comb begin
        st_d = st_q;
        if (swrst) begin
            st_d = '0;
        end else begin
            if (launch) begin
                st_d.run = 1'b1;
                st_d.cnt = '0;
                if (st_q.pend_vld) begin
                    st_d.eff      = st_q.pend;
                    st_d.pend_vld = 1'b0;
                end
            end else if (tick && st_q.run) begin
                if (hit_w) begin
                    st_d.cnt = '0;
                    if (!cont) begin
                        st_d.run = 1'b0;
                    end
                end else begin
                    st_d.cnt = inc_w[CNT_W-1:0];
                end
            end
            if (commit) begin
                if (live || !st_q.run) begin
                    st_d.eff      = commit_val;
                    st_d.pend_vld = 1'b0;
                end else begin
                    st_d.pend     = commit_val;
                    st_d.pend_vld = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign running = st_q.run;

endmodule

// File: rtl/ivt64_regs.sv
module ivt64_regs
    import ivt64_pkg::*;
#(
    parameter int DW     = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap,
    output logic [DW-1:0]     bus_rdata,
    output mode_t             mode,
    output logic              start_req,
    output logic              swrst,
    output logic              commit,
    output logic [CNT_W-1:0]  commit_val,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_PLO  = ADDR_W'(OFS_PLO);
    localparam logic [ADDR_W-1:0] A_PHI  = ADDR_W'(OFS_PHI);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
    localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'(OFS_IST);
    localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(OFS_CLO);
    localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(OFS_CHI);

    typedef struct packed {
        mode_t            mode;
        logic [DW-1:0]    stage_hi;
        logic [CNT_W-1:0] prog;
        logic             ien;
        logic             ist;
        logic [DW-1:0]    snap_hi;
        logic [DW-1:0]    rdata;
    } reg_st_t;

    reg_st_t       st_q, st_d;
    logic          wr_ctrl, wr_mode, wr_plo, wr_phi, wr_ien;
    logic          rd_ist, rd_clo;
    logic [DW-1:0] mode_rv;
    logic [DW-1:0] rd_mux;

    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == A_CTRL);
        wr_mode = bus_wr && (bus_addr == A_MODE);
        wr_plo  = bus_wr && (bus_addr == A_PLO);
        wr_phi  = bus_wr && (bus_addr == A_PHI);
        wr_ien  = bus_wr && (bus_addr == A_IEN);
        rd_ist  = bus_rd && (bus_addr == A_IST);
        rd_clo  = bus_rd && (bus_addr == A_CLO);

        swrst      = wr_ctrl & bus_wdata[CTL_SRST];
        start_req  = wr_ctrl & bus_wdata[CTL_GO];
        commit     = wr_plo;
        commit_val = {st_q.stage_hi, bus_wdata};

        mode_rv                   = '0;
        mode_rv[MD_CONT]          = st_q.mode.cont;
        mode_rv[MD_ALT]           = st_q.mode.alt;
        mode_rv[MD_LIVE]          = st_q.mode.live;
        mode_rv[MD_DIV +: DIV_W]  = st_q.mode.div;

        unique case (bus_addr)
            A_MODE:  rd_mux = mode_rv;
            A_PLO:   rd_mux = st_q.prog[DW-1:0];
            A_PHI:   rd_mux = st_q.prog[CNT_W-1:DW];
            A_IEN:   rd_mux = {{(DW-1){1'b0}}, st_q.ien};
            A_IST:   rd_mux = {{(DW-1){1'b0}}, st_q.ist};
            A_CLO:   rd_mux = count[DW-1:0];
            A_CHI:   rd_mux = st_q.snap_hi;
            default: rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (swrst) begin
            st_d = '0;
        end else begin
            if (wr_mode) begin
                st_d.mode.cont = bus_wdata[MD_CONT];
                st_d.mode.alt  = bus_wdata[MD_ALT];
                st_d.mode.live = bus_wdata[MD_LIVE];
                st_d.mode.div  = bus_wdata[MD_DIV +: DIV_W];
            end
            if (wr_phi) begin
                st_d.stage_hi = bus_wdata;
            end
            if (wr_plo) begin
                st_d.prog = commit_val;
            end
            if (wr_ien) begin
                st_d.ien = bus_wdata[0];
            end
            if (rd_clo) begin
                st_d.snap_hi = count[CNT_W-1:DW];
            end
            // a wrap in the read cycle wins over the clear
            if (wrap) begin
                st_d.ist = 1'b1;
            end else if (rd_ist) begin
                st_d.ist = 1'b0;
            end
            if (bus_rd) begin
                st_d.rdata = rd_mux;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign mode      = st_q.mode;
    assign irq       = st_q.ist & st_q.ien;

endmodule

// File: rtl/ivt64_timer.sv
module ivt64_timer
    import ivt64_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq_o
);

    localparam int CNT_W = 2 * HALF_W;

    mode_t            mode_w;
    logic             start_req_w;
    logic             swrst_w;
    logic             commit_w;
    logic [CNT_W-1:0] commit_val_w;
    logic [CNT_W-1:0] count_w;
    logic             running_w;
    logic             launch_w;
    logic             wrap_w;
    logic             tick_w;

    ivt64_regs #(
        .DW    (HALF_W),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count     (count_w),
        .wrap      (wrap_w),
        .bus_rdata (bus_rdata),
        .mode      (mode_w),
        .start_req (start_req_w),
        .swrst     (swrst_w),
        .commit    (commit_w),
        .commit_val(commit_val_w),
        .irq       (irq_o)
    );

    ivt64_prescale #(
        .PW(DIV_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (launch_w | swrst_w),
        .run     (running_w),
        .alt_sel (mode_w.alt),
        .alt_tick(alt_tick),
        .div     (mode_w.div),
        .tick    (tick_w)
    );

    ivt64_count #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req_w),
        .swrst     (swrst_w),
        .tick      (tick_w),
        .cont      (mode_w.cont),
        .live      (mode_w.live),
        .commit    (commit_w),
        .commit_val(commit_val_w),
        .count     (count_w),
        .running   (running_w),
        .launch    (launch_w),
        .wrap      (wrap_w)
    );

endmodule

// File: rtl/ivt64_checker.sv
module ivt64_checker
    import ivt64_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              start_req,
    input logic              swrst,
    input logic              tick,
    input logic              wrap,
    input logic              running,
    input logic              cont,
    input logic [DIV_W-1:0]  div,
    input logic [CNT_W-1:0]  count,
    input logic              irq_o
);

    // R2: an idle timer holds a zero count
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> count == '0);

    // R2: a start while running leaves the count untouched
    a_r2_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        running && start_req && !swrst && !tick |=> $stable(count));

    // R3: with a divide above zero, ticks never come back to back
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick && div != '0 && !swrst && !(bus_wr && bus_addr == ADDR_W'(OFS_MODE)) |=> !tick);

    // R5: a wrap leaves the counter at zero
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> count == '0);

    // R6: single-shot stops at the first wrap
    a_r6_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
        wrap && !cont && !swrst |=> !running);

    // R7: reading status without a coincident wrap drops the interrupt
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == ADDR_W'(OFS_IST) && !wrap |=> !irq_o);

    // R12: software reset idles the block
    a_r12_swrst_idle: assert property (@(posedge clk) disable iff (!rst_n)
        swrst |=> !running && count == '0 && !irq_o);

endmodule

bind ivt64_timer ivt64_checker #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .start_req(start_req_w),
    .swrst    (swrst_w),
    .tick     (tick_w),
    .wrap     (wrap_w),
    .running  (running_w),
    .cont     (mode_w.cont),
    .div      (mode_w.div),
    .count    (count_w),
    .irq_o    (irq_o)
);

// File: tb/sim_ivt64_timer.sv
`timescale 1ns/1ps
module sim_ivt64_timer;

    localparam int DW = 16;
    localparam int AW = 8;
    localparam longint WD_LIMIT = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alt_tick = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    ivt64_timer #(.HALF_W(DW), .ADDR_W(AW)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .alt_tick (alt_tick),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o)
    );

    always #2 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errs = 0;
    bit done = 0;

    // scoreboard
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    logic          rd_pend = 1'b0;

    // counter model
    longint g_t0 = 0;
    longint g_p = 0;
    longint g_n = 1;
    bit     g_cont = 1;
    longint g_snap = 0;
    longint last_edge = 0;

    function automatic longint model(longint e);
        longint j;
        j = (e - g_t0) / (g_p + 1);
        if (!g_cont) return (j >= g_n) ? 0 : j;
        return j % g_n;
    endfunction

    task automatic chk_eq(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_pend <= bus_rd;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                chk_eq("scoreboard underrun", 1, 0);
            end else begin
                chk_eq(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    always @(negedge clk) begin
        if (cyc > WD_LIMIT && !done) begin
            done = 1;
            errs++;
            $display("FAIL watchdog: cycle %0d, limit %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        last_edge = cyc;
    endtask

    task automatic rd(input logic [7:0] a, input logic [DW-1:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // low counter read; expected value from the model at the sampling edge
    task automatic rd_cnt(input string tag);
        longint v;
        @(negedge clk);
        v = model(cyc);
        g_snap = v >> DW;
        bus_rd = 1'b1; bus_addr = 8'h20;
        exp_q.push_back(v[DW-1:0]); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_to(longint e);
        while (cyc < e) @(negedge clk);
    endtask

    task automatic start_run(longint p, longint n, bit c);
        wr(8'h00, 16'h0001);
        g_t0 = last_edge; g_p = p; g_n = n; g_cont = c;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h00, 0, "R1"); rd(8'h04, 0, "R1"); rd(8'h08, 0, "R1");
        rd(8'h0C, 0, "R1"); rd(8'h10, 0, "R1"); rd(8'h1C, 0, "R1");
        rd(8'h20, 0, "R1"); rd(8'h24, 0, "R1");
        chk_eq("R1 irq", irq_o, 0);

        // R13: undefined and unaligned offsets
        rd(8'h14, 0, "R13"); rd(8'h18, 0, "R13");
        rd(8'h02, 0, "R13"); rd(8'h30, 0, "R13");

        // R9: staging and commit
        wr(8'h0C, 16'h0001);
        rd(8'h0C, 0, "R9 staged only");
        wr(8'h08, 16'h0005);
        rd(8'h08, 16'h0005, "R9 low");
        rd(8'h0C, 16'h0001, "R9 high");

        // R2 R5 R6 R7: continuous, period 10
        wr(8'h0C, 0); wr(8'h08, 10);
        wr(8'h10, 1);
        rd(8'h10, 1, "R7 enable");
        wr(8'h04, 16'h0001);
        rd(8'h04, 16'h0001, "R6 mode");
        start_run(0, 10, 1);
        rd_cnt("R2 counting");
        wait_to(g_t0 + 6);
        wr(8'h00, 16'h0001);          // ignored while running
        rd_cnt("R2 busy start");
        wait_to(g_t0 + 11);
        chk_eq("R7 irq raised", irq_o, 1);
        rd(8'h1C, 1, "R5 flag");
        chk_eq("R7 irq cleared", irq_o, 0);
        rd(8'h1C, 0, "R7 cleared on read");
        wait_to(g_t0 + 24);
        rd_cnt("R6 continuous");
        chk_eq("R7 irq again", irq_o, 1);

        // R12: software reset
        wr(8'h00, 16'h0101);
        chk_eq("R12 irq", irq_o, 0);
        rd(8'h04, 0, "R12 mode"); rd(8'h10, 0, "R12 enable");
        rd(8'h1C, 0, "R12 status"); rd(8'h08, 0, "R12 period");
        repeat (5) @(negedge clk);
        rd(8'h20, 0, "R12 stopped");

        // R10 without live bit, R6 single-shot
        wr(8'h0C, 0); wr(8'h08, 40);
        wr(8'h04, 16'h0000);
        start_run(0, 40, 0);
        wait_to(g_t0 + 3);
        wr(8'h08, 6);
        wait_to(g_t0 + 15);
        rd_cnt("R10 held period");
        rd(8'h08, 6, "R9 committed");
        wait_to(g_t0 + 45);
        rd_cnt("R6 stopped");
        rd(8'h1C, 1, "R6 flag");
        start_run(0, 6, 0);
        wait_to(g_t0 + 4);
        rd_cnt("R10 applied at start");
        wait_to(g_t0 + 10);
        rd_cnt("R6 stopped again");
        rd(8'h1C, 1, "R10 flag new period");

        // R10 with live bit
        wr(8'h00, 16'h0100);
        wr(8'h08, 100);
        wr(8'h04, 16'h0011);
        start_run(0, 100, 1);
        wait_to(g_t0 + 2);
        wr(8'h08, 6);
        g_n = 6;
        wait_to(g_t0 + 15);
        rd_cnt("R10 live");
        rd(8'h1C, 1, "R10 live flag");

        // R3: divide by 4
        wr(8'h00, 16'h0100);
        wr(8'h08, 50);
        wr(8'h04, 16'h0301);
        rd(8'h04, 16'h0301, "R3 mode readback");
        start_run(3, 50, 1);
        wait_to(g_t0 + 30);
        rd_cnt("R3 divided");
        wait_to(g_t0 + 43);
        rd_cnt("R3 divided later");

        // R4: alternate enable, divide by 2
        wr(8'h00, 16'h0100);
        wr(8'h08, 50);
        wr(8'h04, 16'h0109);
        wr(8'h00, 16'h0001);
        repeat (20) @(negedge clk);
        rd(8'h20, 0, "R4 frozen");
        @(negedge clk);
        alt_tick = 1'b1;
        repeat (6) @(negedge clk);
        alt_tick = 1'b0;
        rd(8'h20, 3, "R4 six enables");
        repeat (10) @(negedge clk);
        rd(8'h20, 3, "R4 held");

        // R8 R11: zero period, cross the half boundary
        wr(8'h00, 16'h0100);
        wr(8'h04, 16'h0001);
        start_run(0, 64'hFFFF_FFFF, 1);
        wait_to(g_t0 + 65528);
        rd_cnt("R8 low below boundary");
        repeat (20) @(negedge clk);
        rd(8'h24, g_snap[DW-1:0], "R8 captured high");
        rd_cnt("R11 no early wrap");
        rd(8'h24, g_snap[DW-1:0], "R8 high after boundary");
        rd(8'h1C, 0, "R11 no flag");

        repeat (3) @(negedge clk);
        chk_eq("scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule